// File: doc/BRIEF.md
# Shifted-Duty Half-Bridge Gate Timing Generator

This block produces the gate timing for a half-bridge converter with two main switches (A and B) and one auxiliary clamp switch. A free-running digital carrier counter replaces the analog ramp and comparators. One duty command sets both main pulses to the same width. The pulses are placed back to back around the carrier wrap. Drive A has a movable rising edge and ends when the carrier wraps. Drive B starts a short, programmable dead time after the wrap and has a movable falling edge. Switch B therefore turns on soon after switch A turns off.

The auxiliary drive is the inverse of drive A, with a delay added only to its rising edge. It turns on while B is conducting and turns off one clock before A turns on. At a 125 MHz clock, a carrier period of 625 clocks gives 200 kHz and 312 clocks gives about 400 kHz. The period, duty, dead-time and auxiliary-delay settings are taken only at the carrier wrap, or at any clock while the block is disabled.

Top module: `dcs_hb_pwm`

## Requirements
- R1: The carrier period is Pe = max(period_i, 4) clocks. Drive B rises exactly once every Pe clocks. Settings of 625 and 312 give 200 kHz and about 400 kHz from a 125 MHz clock.
- R2: Both main pulses have the same width W in every period. W = min(duty_i, floor(Pe/2) - De), and W = 0 when De >= floor(Pe/2).
- R3: Count the first clock edge with en high as carrier count 0. The outputs sampled after an edge reflect that edge's count. Drive A is high for counts Pe-W to Pe-1, so it ends at the wrap.
- R4: The dead time is De = max(dead_i, 1). Drive B is high for counts De to De+W-1, so it rises De clocks after A falls. A and B are never high at the same time.
- R5: Raising the duty by n moves the rising edge of A n clocks earlier and the falling edge of B n clocks later. The rising edge of B does not move.
- R6: The auxiliary drive is high for counts De+X to Pe-W-2, where X = min(aux_dly_i, W-1). It is high only when W > 0. It therefore rises while B is high and is low in the clock before A rises.
- R7: The settings are captured only at count Pe-1 or while en is low. A change in the middle of a period first takes effect at count 0 of the next period.
- R8: While rst_n is low, all three drives are low. After en is sampled low, all three drives are low from the next clock, and the carrier restarts at count 0 when en returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable |
| period_i | input | CNT_W | Carrier period in clocks |
| duty_i | input | CNT_W | Pulse width command in clocks |
| dead_i | input | DT_W | Dead time in clocks (0 acts as 1) |
| aux_dly_i | input | AUX_W | Auxiliary rising-edge delay after B turns on |
| drv_a_o | output | 1 | Main switch A drive (movable rising edge) |
| drv_b_o | output | 1 | Main switch B drive (movable falling edge) |
| drv_aux_o | output | 1 | Auxiliary clamp switch drive |

## Verification
The hardest situation to reach from the ports is a settings change that lands mid-period, including a change of period length. The bench changes the inputs at a chosen count inside period 0. It then predicts every output from the old settings up to the wrap and from the new settings, with the new period length, after it. The clamp corners are reached by a sweep over short periods with every duty up to past the limit, dead times of 0 to 3 and several auxiliary delays. These corners are: width forced to zero, an auxiliary window that collapses to nothing, and a period below the minimum.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  // Lower clamp on an unsigned quantity.
  function automatic logic [31:0] f_clamp_lo(input logic [31:0] v, input logic [31:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  // Pulse width from effective period, duty command and effective dead time.
  function automatic logic [31:0] f_width(input logic [31:0] per_e,
                                          input logic [31:0] duty,
                                          input logic [31:0] dead_e);
    logic [31:0] half;
    logic [31:0] room;
    half = per_e >> 1;
    if (dead_e >= half) return 32'd0;
    room = half - dead_e;
    return (duty < room) ? duty : room;
  endfunction

  // Auxiliary turn-on lead inside the B pulse.
  function automatic logic [31:0] f_aux_lead(input logic [31:0] w, input logic [31:0] dly);
    if (w == 32'd0) return 32'd0;
    return (dly < w - 32'd1) ? dly : (w - 32'd1);
  endfunction

  typedef struct packed {
    logic a;
    logic b;
    logic aux;
  } dcs_drv_t;

endpackage

// File: rtl/dcs_carrier.sv
module dcs_carrier #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned DT_W    = 8,
  parameter int unsigned AUX_W   = 8,
  parameter int unsigned PER_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic [AUX_W-1:0] adly_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [DT_W-1:0]  dead_o,
  output logic [AUX_W-1:0] adly_o,
  output logic             wrap_o
);
  import dcs_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, per_q, duty_q;
  logic [DT_W-1:0]  dead_q;
  logic [AUX_W-1:0] adly_q;
  logic             wrap;
  logic             take_cmd;

  assign wrap     = en && (cnt_q == per_q - CNT_ONE);
  assign take_cmd = !en || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= CNT_W'(PER_MIN);
      duty_q <= '0;
      dead_q <= DT_W'(1);
      adly_q <= '0;
    end else if (take_cmd) begin
      per_q  <= CNT_W'(f_clamp_lo(32'(per_i), 32'(PER_MIN)));
      duty_q <= duty_i;
      dead_q <= DT_W'(f_clamp_lo(32'(dead_i), 32'd1));
      adly_q <= adly_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign dead_o = dead_q;
  assign adly_o = adly_q;
  assign wrap_o = wrap;

  // R1: the carrier returns to zero after the last count
  p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  // R1: the count never leaves the active period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per_q);

  // R7: settings stay frozen inside a running period
  p_hold_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(duty_q) && $stable(per_q) && $stable(dead_q) && $stable(adly_q)));

endmodule

// File: rtl/dcs_edges.sv
module dcs_edges #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 8,
  parameter int unsigned AUX_W = 8
) (
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic [AUX_W-1:0] adly_i,
  output logic             live_o,
  output logic [CNT_W-1:0] b_start_o,
  output logic [CNT_W-1:0] b_stop_o,
  output logic [CNT_W-1:0] a_start_o,
  output logic [CNT_W-1:0] aux_on_o,
  output logic [CNT_W-1:0] aux_off_o
);
  import dcs_pkg::*;

  logic [31:0] w32;
  logic [31:0] x32;

  always_comb begin
    w32       = f_width(32'(per_i), 32'(duty_i), 32'(dead_i));
    x32       = f_aux_lead(w32, 32'(adly_i));
    live_o    = (w32 != 32'd0);
    b_start_o = CNT_W'(32'(dead_i));
    b_stop_o  = CNT_W'(32'(dead_i) + w32);
    a_start_o = CNT_W'(32'(per_i) - w32);
    aux_on_o  = CNT_W'(32'(dead_i) + x32);
    aux_off_o = CNT_W'(32'(per_i) - w32 - 32'd1);
  end

endmodule

// File: rtl/dcs_drive.sv
module dcs_drive #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             live_i,
  input  logic [CNT_W-1:0] b_start_i,
  input  logic [CNT_W-1:0] b_stop_i,
  input  logic [CNT_W-1:0] a_start_i,
  input  logic [CNT_W-1:0] aux_on_i,
  input  logic [CNT_W-1:0] aux_off_i,
  output logic             drv_a_o,
  output logic             drv_b_o,
  output logic             drv_aux_o
);
  import dcs_pkg::*;

  dcs_drv_t nxt;
  dcs_drv_t cur;

  always_comb begin
    nxt.a   = en && live_i && (cnt_i >= a_start_i);
    nxt.b   = en && (cnt_i >= b_start_i) && (cnt_i < b_stop_i);
    nxt.aux = en && live_i && (cnt_i >= aux_on_i) && (cnt_i < aux_off_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  assign drv_a_o   = cur.a;
  assign drv_b_o   = cur.b;
  assign drv_aux_o = cur.aux;

  // R4: the two main switches never conduct together
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur.a && cur.b));

  // R3: when A ends at the wrap, B is still off (dead time)
  p_a_fall_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur.a) |-> !cur.b);

  // R6: auxiliary turns on only while B conducts
  p_aux_in_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur.aux) |-> cur.b);

  // R6: auxiliary already off in the clock before A turns on
  p_aux_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur.a) |-> !$past(cur.aux));

  // R8: disable forces all drives low on the next clock
  p_forced_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(cur.a || cur.b || cur.aux));

endmodule

// File: rtl/dcs_hb_pwm.sv
module dcs_hb_pwm #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned DT_W    = 8,
  parameter int unsigned AUX_W   = 8,
  parameter int unsigned PER_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic [AUX_W-1:0] aux_dly_i,
  output logic             drv_a_o,
  output logic             drv_b_o,
  output logic             drv_aux_o
);

  logic [CNT_W-1:0] cnt, per_q, duty_q;
  logic [DT_W-1:0]  dead_q;
  logic [AUX_W-1:0] adly_q;
  logic             wrap;
  logic             live;
  logic [CNT_W-1:0] b_start, b_stop, a_start, aux_on, aux_off;

  dcs_carrier #(
    .CNT_W(CNT_W), .DT_W(DT_W), .AUX_W(AUX_W), .PER_MIN(PER_MIN)
  ) u_carrier (
    .clk(clk), .rst_n(rst_n), .en(en),
    .per_i(period_i), .duty_i(duty_i), .dead_i(dead_i), .adly_i(aux_dly_i),
    .cnt_o(cnt), .per_o(per_q), .duty_o(duty_q), .dead_o(dead_q), .adly_o(adly_q),
    .wrap_o(wrap)
  );

  dcs_edges #(
    .CNT_W(CNT_W), .DT_W(DT_W), .AUX_W(AUX_W)
  ) u_edges (
    .per_i(per_q), .duty_i(duty_q), .dead_i(dead_q), .adly_i(adly_q),
    .live_o(live), .b_start_o(b_start), .b_stop_o(b_stop),
    .a_start_o(a_start), .aux_on_o(aux_on), .aux_off_o(aux_off)
  );

  dcs_drive #(
    .CNT_W(CNT_W)
  ) u_drive (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt_i(cnt), .live_i(live),
    .b_start_i(b_start), .b_stop_i(b_stop), .a_start_i(a_start),
    .aux_on_i(aux_on), .aux_off_i(aux_off),
    .drv_a_o(drv_a_o), .drv_b_o(drv_b_o), .drv_aux_o(drv_aux_o)
  );

  // R1: the wrap strobe is seen only while the block runs
  p_wrap_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> en);

endmodule

// File: tb/sim_dcs_hb_pwm.sv
module sim_dcs_hb_pwm;
  // 125 MHz clock: 8 time units per period
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, en;
  logic [11:0] period_i, duty_i;
  logic [7:0]  dead_i, aux_dly_i;
  logic        drv_a, drv_b, drv_aux;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dcs_hb_pwm u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_i(period_i), .duty_i(duty_i), .dead_i(dead_i), .aux_dly_i(aux_dly_i),
    .drv_a_o(drv_a), .drv_b_o(drv_b), .drv_aux_o(drv_aux)
  );

  function automatic int e_per(int p);  return (p < 4) ? 4 : p; endfunction
  function automatic int e_dead(int d); return (d < 1) ? 1 : d; endfunction
  function automatic int e_w(int p, int duty, int dead);
    int room;
    room = e_per(p) / 2 - e_dead(dead);
    if (room <= 0) return 0;
    return (duty < room) ? duty : room;
  endfunction
  function automatic int e_x(int w, int ad);
    if (w == 0) return 0;
    return (ad < w - 1) ? ad : w - 1;
  endfunction
  // {a, b, aux} expected at carrier count c
  function automatic logic [2:0] expect_at(int p, int duty, int dead, int ad, int c);
    int pe, de, w, x;
    logic ea, eb, ex;
    pe = e_per(p); de = e_dead(dead); w = e_w(p, duty, dead); x = e_x(w, ad);
    ea = (w > 0) && (c >= pe - w);
    eb = (c >= de) && (c < de + w);
    ex = (w > 0) && (c >= de + x) && (c < pe - w - 1);
    return {ea, eb, ex};
  endfunction

  task automatic report(string req, bit ok, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_cfg(int p0, int d0, int dt0, int ad0, int chg_k,
                         int p1, int d1, int dt1, int ad1, int ncyc, string ctx,
                         output int a_rise, output int b_fall);
    int bad_k[3];
    int bad_act[3];
    int bad_exp[3];
    int ov_k, pe0, nb_rise, rise0, rise1, cnt_a, cnt_b;
    logic [2:0] prev;
    for (int i = 0; i < 3; i++) begin bad_k[i] = -1; bad_act[i] = 0; bad_exp[i] = 0; end
    ov_k = -1; nb_rise = 0; rise0 = 0; rise1 = 0; cnt_a = 0; cnt_b = 0;
    a_rise = -1; b_fall = -1; prev = 3'b000;
    pe0 = e_per(p0);
    @(negedge clk);
    en = 1'b0; period_i = 12'(p0); duty_i = 12'(d0); dead_i = 8'(dt0); aux_dly_i = 8'(ad0);
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      logic [2:0] act, exp;
      @(negedge clk);
      act = {drv_a, drv_b, drv_aux};
      if (k < pe0) exp = expect_at(p0, d0, dt0, ad0, k);
      else         exp = expect_at(p1, d1, dt1, ad1, (k - pe0) % e_per(p1));
      for (int i = 0; i < 3; i++)
        if (act[2-i] !== exp[2-i] && bad_k[i] < 0) begin
          bad_k[i] = k; bad_act[i] = int'(act[2-i]); bad_exp[i] = int'(exp[2-i]);
        end
      if (act[2] && act[1] && ov_k < 0) ov_k = k;
      if (act[1] && !prev[1]) begin
        if (nb_rise == 0) rise0 = k; else if (nb_rise == 1) rise1 = k;
        nb_rise++;
      end
      if (act[2] && !prev[2] && a_rise < 0) a_rise = k;
      if (!act[1] && prev[1] && b_fall < 0) b_fall = k;
      if (k < pe0) begin cnt_a += int'(act[2]); cnt_b += int'(act[1]); end
      prev = act;
      if (k == chg_k) begin
        period_i = 12'(p1); duty_i = 12'(d1); dead_i = 8'(dt1); aux_dly_i = 8'(ad1);
      end
    end
    report((ctx != "") ? ctx : "R3", bad_k[0] < 0,
           $sformatf("drive A p=%0d duty=%0d dead=%0d cycle=%0d", p0, d0, dt0, bad_k[0]),
           bad_act[0], bad_exp[0]);
    report((ctx != "") ? ctx : "R4", bad_k[1] < 0,
           $sformatf("drive B p=%0d duty=%0d dead=%0d cycle=%0d", p0, d0, dt0, bad_k[1]),
           bad_act[1], bad_exp[1]);
    report((ctx != "") ? ctx : "R6", bad_k[2] < 0,
           $sformatf("aux p=%0d duty=%0d dead=%0d dly=%0d cycle=%0d", p0, d0, dt0, ad0, bad_k[2]),
           bad_act[2], bad_exp[2]);
    report("R4", ov_k < 0, $sformatf("overlap p=%0d duty=%0d cycle", p0, d0), ov_k, -1);
    if (chg_k < 0) begin
      report("R2", cnt_a == cnt_b && cnt_a == e_w(p0, d0, dt0),
             $sformatf("width A vs B p=%0d duty=%0d dead=%0d (B width shown)", p0, d0, dt0),
             cnt_b, e_w(p0, d0, dt0));
      if (e_w(p0, d0, dt0) > 0 && nb_rise >= 2)
        report("R1", (rise1 - rise0) == pe0,
               $sformatf("B rise spacing p=%0d", p0), rise1 - rise0, pe0);
    end
    en = 1'b0;
    @(negedge clk);
    report("R8", {drv_a, drv_b, drv_aux} == 3'b000, "drives after en low",
           int'({drv_a, drv_b, drv_aux}), 0);
  endtask

  initial begin
    #1520000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired before the run completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int ar, bf, ar3, bf3, ar5, bf5;
    rst_n = 1'b0; en = 1'b0;
    period_i = 12'd10; duty_i = 12'd3; dead_i = 8'd1; aux_dly_i = 8'd0;
    repeat (3) @(negedge clk);
    report("R8", drv_a == 1'b0, "A in reset", int'(drv_a), 0);
    report("R8", drv_b == 1'b0, "B in reset", int'(drv_b), 0);
    report("R8", drv_aux == 1'b0, "aux in reset", int'(drv_aux), 0);
    rst_n = 1'b1;

    // Sweep of short periods, all duties up to past the clamp, dead 0..3, several aux delays
    for (int p = 2; p <= 16; p++)
      for (int d = 0; d <= e_per(p) / 2 + 1; d++)
        for (int dt = 0; dt <= 3; dt++)
          for (int ai = 0; ai < 3; ai++) begin
            int ad;
            ad = (ai == 0) ? 0 : ((ai == 1) ? 1 : 5);
            run_cfg(p, d, dt, ad, -1, p, d, dt, ad, 3 * e_per(p), "", ar, bf);
          end

    // R1: target frequencies at 125 MHz
    run_cfg(625, 100, 5, 10, -1, 625, 100, 5, 10, 2 * 625 + 5, "", ar, bf);
    run_cfg(312, 150, 3, 200, -1, 312, 150, 3, 200, 2 * 312 + 5, "", ar, bf);
    run_cfg(312, 400, 3, 7, -1, 312, 400, 3, 7, 2 * 312 + 5, "", ar, bf);

    // R7: mid-period change of duty, dead and aux; then of period length too
    run_cfg(10, 2, 1, 0, 4, 10, 4, 2, 1, 30, "R7", ar, bf);
    run_cfg(10, 3, 1, 1, 3, 14, 5, 2, 2, 40, "R7", ar, bf);
    run_cfg(16, 6, 2, 3, 10, 6, 1, 1, 0, 30, "R7", ar, bf);

    // R5: edges move in opposite directions with duty
    run_cfg(16, 3, 2, 0, -1, 16, 3, 2, 0, 16, "", ar3, bf3);
    run_cfg(16, 5, 2, 0, -1, 16, 5, 2, 0, 16, "", ar5, bf5);
    report("R5", ar5 == ar3 - 2, "A rise shift for duty +2", ar5, ar3 - 2);
    report("R5", bf5 == bf3 + 2, "B fall shift for duty +2", bf5, bf3 + 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule